// File: doc/BRIEF.md
# Flash Command Interpreter with Status Register

This block is the control front end of a byte-wide flash memory model. It watches a chip-enable and a write-enable strobe, and it takes an address and a data byte each time write-enable rises while chip-enable is held low. It reads each captured byte as a command or as the second beat of a two-beat sequence. It decides which source the read path shows: the array, the status register or the identifier bytes. It also starts byte programs and block erases, holds them busy for a counted number of cycles, and keeps an 8-bit status register with sticky error flags.

A program is a setup beat followed by a beat that carries the target address and data. An erase is a setup beat followed by a confirm beat whose address must fall in the same block as the setup address. The program-voltage-OK input is sampled only once a full sequence has arrived. A low level aborts the operation and sets a lock flag, and that flag blocks further operations until software clears the status register. A running erase can be paused and then resumed. The storage array and the voltage sensing sit outside this block. It hands one-cycle program and erase strobes, with the latched address and data, to the array model.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write is taken only on a rising edge of `we_n` while `ce_n` is low. A write strobe given while `ce_n` is high has no effect.
- R2: After reset, `rd_mode` is 2'b00 (array), `ready` is 1, both strobes are 0, and the status byte reads 80h.
- R3: Command FFh selects `rd_mode` 2'b00, 70h selects 2'b01 (status) and 90h selects 2'b10 (identifier). The mode holds until another command changes it. In identifier mode `rd_data` is MFG_ID when `addr[0]`=0 and DEV_ID when `addr[0]`=1. In array mode `rd_data` is 00h.
- R4: Command 40h followed by a second beat gives exactly one `prog_stb` pulse, with `op_addr`/`op_data` equal to that beat's address and data. `ready` is then low for exactly PROG_CYC cycles.
- R5: Command 20h followed by D0h at an address in the same block (same `addr` bits above BLK_W) gives one `erase_stb` pulse, with `op_addr` equal to the confirm address. `ready` is then low for exactly ERASE_CYC cycles.
- R6: A confirm beat whose data is not D0h, or whose block differs from the setup block, sets status bits 5 and 4. It gives no strobe, and `ready` stays 1.
- R7: If `vpp_ok` is 0 when the second beat of a program or erase arrives, status bit 3 is set and no strobe is issued.
- R8: While status bit 3 is 1, commands 40h and 20h are ignored. Command 50h clears status bits 5, 4 and 3.
- R9: While a program or erase runs, FFh is ignored: `rd_mode` stays 2'b01 and status bit 7 reads 0.
- R10: B0h during an erase pauses it. `ready` goes to 1, status bit 6 reads 1, the busy count is frozen, and FFh/70h may change the read mode. D0h resumes the erase for its remaining cycles.
- R11: Status bit 7 is ready (1 = ready) and status bits 2 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, a rising edge captures a beat |
| addr | input | ADDR_W | Bus address for writes and identifier reads |
| din | input | 8 | Bus data for writes |
| vpp_ok | input | 1 | Program voltage is within range |
| rd_mode | output | 2 | Read source: 00 array, 01 status, 10 identifier |
| rd_data | output | 8 | Status or identifier byte (00h in array mode) |
| ready | output | 1 | 1 = idle or suspended, 0 = program/erase running |
| prog_stb | output | 1 | One-cycle program start |
| erase_stb | output | 1 | One-cycle erase start |
| op_addr | output | ADDR_W | Latched target address of the last started operation |
| op_data | output | 8 | Latched data of the last started operation |

## Verification
Byte programs are driven at two different address and data patterns, so that a stuck or swapped latch shows in the scoreboard. Erases are confirmed at a far offset inside the setup block, which tells a block compare apart from a full-address compare, and rejected confirms use both a wrong data byte and a neighbouring block. The voltage-low path is followed by setup bytes that must be ignored and then a clear, which separates the lock from a plain one-shot error. A suspend in the middle of an erase checks that the busy count is frozen and not restarted.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'b00,
        RM_STATUS = 2'b01,
        RM_IDENT  = 2'b10
    } rd_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_ESETUP,
        PH_PROG,
        PH_ERASE,
        PH_SUSP
    } phase_e;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_WRITE_SETUP  = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_READ_ID      = 8'h90;

    // sticky error flags kept between operations
    typedef struct packed {
        logic ers_err;
        logic wr_err;
        logic vpp_low;
    } sticky_t;

    function automatic logic [7:0] pack_status(logic rdy, logic susp, sticky_t s);
        return {rdy, susp, s.ers_err, s.wr_err, s.vpp_low, 3'b000};
    endfunction

    function automatic logic busy_phase(phase_e p);
        return (p == PH_PROG) || (p == PH_ERASE);
    endfunction

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic we_q;
    logic rise;

    assign rise = we_n && !we_q && !ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            we_q   <= we_n;
            wr_vld <= rise;
            if (rise) begin
                wr_addr <= addr;
                wr_data <= din;
            end
        end
    end

    // a captured beat is always a single-cycle pulse
    assert_single_beat_R1: assert property (@(posedge clk) disable iff (rst)
        wr_vld |=> !wr_vld);

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = run && (cnt == CNT_W'(1));

    // a running operation never sees an exhausted counter
    assert_run_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt != '0);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BLK_W     = 16,
    parameter int CNT_W     = 8,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              vpp_ok,
    input  logic              tmr_last,
    output phase_e            phase,
    output rd_mode_e          mode,
    output sticky_t           sticky,
    output logic              prog_stb,
    output logic              erase_stb,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              tmr_run
);
    localparam int HI_W = ADDR_W - BLK_W;

    phase_e            ph_n;
    rd_mode_e          mode_n;
    sticky_t           st_n;
    logic              ps_n, es_n;
    logic [ADDR_W-1:0] oa_n;
    logic [7:0]        od_n;
    logic [HI_W-1:0]   sblk, sblk_n;

    assign tmr_run = busy_phase(phase);

    always_comb begin
        ph_n     = phase;
        mode_n   = mode;
        st_n     = sticky;
        ps_n     = 1'b0;
        es_n     = 1'b0;
        oa_n     = op_addr;
        od_n     = op_data;
        sblk_n   = sblk;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase)
            PH_PROG, PH_ERASE: begin
                if (tmr_last)
                    ph_n = PH_IDLE;
                else if (wr_vld && phase == PH_ERASE && wr_data == CMD_SUSPEND)
                    ph_n = PH_SUSP;
            end
            PH_SUSP: begin
                if (wr_vld) begin
                    case (wr_data)
                        CMD_CONFIRM: begin
                            ph_n   = PH_ERASE;
                            mode_n = RM_STATUS;
                        end
                        CMD_READ_ARRAY:  mode_n = RM_ARRAY;
                        CMD_READ_STATUS: mode_n = RM_STATUS;
                        default: ;
                    endcase
                end
            end
            PH_WSETUP: begin
                if (wr_vld) begin
                    ph_n = PH_IDLE;
                    if (vpp_ok) begin
                        ph_n     = PH_PROG;
                        ps_n     = 1'b1;
                        oa_n     = wr_addr;
                        od_n     = wr_data;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(PROG_CYC);
                    end else begin
                        st_n.vpp_low = 1'b1;
                    end
                end
            end
            PH_ESETUP: begin
                if (wr_vld) begin
                    ph_n = PH_IDLE;
                    if (wr_data != CMD_CONFIRM || wr_addr[ADDR_W-1:BLK_W] != sblk) begin
                        st_n.ers_err = 1'b1;
                        st_n.wr_err  = 1'b1;
                    end else if (vpp_ok) begin
                        ph_n     = PH_ERASE;
                        es_n     = 1'b1;
                        oa_n     = wr_addr;
                        od_n     = wr_data;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(ERASE_CYC);
                    end else begin
                        st_n.vpp_low = 1'b1;
                    end
                end
            end
            default: begin
                if (wr_vld) begin
                    case (wr_data)
                        CMD_READ_ARRAY:   mode_n = RM_ARRAY;
                        CMD_READ_STATUS:  mode_n = RM_STATUS;
                        CMD_READ_ID:      mode_n = RM_IDENT;
                        CMD_CLEAR_STATUS: st_n   = '0;
                        CMD_WRITE_SETUP: begin
                            if (!sticky.vpp_low) begin
                                ph_n   = PH_WSETUP;
                                mode_n = RM_STATUS;
                            end
                        end
                        CMD_ERASE_SETUP: begin
                            if (!sticky.vpp_low) begin
                                ph_n   = PH_ESETUP;
                                mode_n = RM_STATUS;
                                sblk_n = wr_addr[ADDR_W-1:BLK_W];
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            mode      <= RM_ARRAY;
            sticky    <= '0;
            prog_stb  <= 1'b0;
            erase_stb <= 1'b0;
            op_addr   <= '0;
            op_data   <= '0;
            sblk      <= '0;
        end else begin
            phase     <= ph_n;
            mode      <= mode_n;
            sticky    <= st_n;
            prog_stb  <= ps_n;
            erase_stb <= es_n;
            op_addr   <= oa_n;
            op_data   <= od_n;
            sblk      <= sblk_n;
        end
    end

    assert_strobe_vpp_R7: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || erase_stb) |-> $past(vpp_ok));

    assert_no_start_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || erase_stb) |-> !$past(sticky.vpp_low));

    assert_prog_after_setup_R4: assert property (@(posedge clk) disable iff (rst)
        prog_stb |-> $past(phase) == PH_WSETUP);

    assert_erase_after_setup_R5: assert property (@(posedge clk) disable iff (rst)
        erase_stb |-> $past(phase) == PH_ESETUP);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter int          BLK_W     = 16,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 40,
    parameter logic [7:0]  MFG_ID    = 8'h89,
    parameter logic [7:0]  DEV_ID    = 8'hA2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              vpp_ok,
    output logic [1:0]        rd_mode,
    output logic [7:0]        rd_data,
    output logic              ready,
    output logic              prog_stb,
    output logic              erase_stb,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              wr_vld;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    phase_e            phase;
    rd_mode_e          mode;
    sticky_t           sticky;
    logic              tmr_load, tmr_run, tmr_last;
    logic [CNT_W-1:0]  tmr_val;

    flash_wr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_cmd_seq #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .vpp_ok(vpp_ok), .tmr_last(tmr_last), .phase(phase), .mode(mode),
        .sticky(sticky), .prog_stb(prog_stb), .erase_stb(erase_stb),
        .op_addr(op_addr), .op_data(op_data), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .tmr_run(tmr_run)
    );

    flash_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .last(tmr_last)
    );

    assign ready   = !busy_phase(phase);
    assign rd_mode = mode;

    always_comb begin
        case (mode)
            RM_STATUS: rd_data = pack_status(ready, phase == PH_SUSP, sticky);
            RM_IDENT:  rd_data = addr[0] ? DEV_ID : MFG_ID;
            default:   rd_data = 8'h00;
        endcase
    end

    // while busy the read path is held on status
    assert_busy_status_R9: assert property (@(posedge clk) disable iff (rst)
        !ready |-> mode == RM_STATUS);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 20;
    localparam int PCY = 8;
    localparam int ECY = 40;

    logic          clk = 1'b0;
    logic          rst, ce_n, we_n, vpp_ok;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [1:0]    rd_mode;
    logic [7:0]    rd_data;
    logic          ready, prog_stb, erase_stb;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .BLK_W(16), .PROG_CYC(PCY), .ERASE_CYC(ECY),
                     .MFG_ID(8'h89), .DEV_ID(8'hA2)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .vpp_ok(vpp_ok), .rd_mode(rd_mode), .rd_data(rd_data), .ready(ready),
        .prog_stb(prog_stb), .erase_stb(erase_stb), .op_addr(op_addr), .op_data(op_data)
    );

    typedef struct {
        bit            er;
        logic [AW-1:0] a;
        logic [7:0]    d;
    } exp_t;

    exp_t q[$];
    int nchk = 0, nfail = 0, busy_cycles = 0, strobes = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_op(input bit er, input logic [AW-1:0] a, input logic [7:0] d);
        exp_t e;
        e.er = er; e.a = a; e.d = d;
        q.push_back(e);
    endtask

    // monitor: scoreboard for strobes, busy-cycle counter
    always @(negedge clk) begin
        if (!rst) begin
            if (!ready) busy_cycles++;
            if (prog_stb || erase_stb) begin
                strobes++;
                if (q.size() == 0) begin
                    chk("R4/R5 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R4/R5 strobe kind", {30'd0, erase_stb, prog_stb}, e.er ? 2 : 1);
                    chk("R4/R5 op_addr", op_addr, e.a);
                    chk("R4/R5 op_data", op_data, e.d);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = 0; we_n = 0; addr = a; din = d;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
        @(negedge clk);
    endtask

    task automatic wr_noce(input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = 1; we_n = 0; addr = a; din = d;
        @(negedge clk); we_n = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle;
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int s0;
        rst = 1; ce_n = 1; we_n = 1; addr = '0; din = '0; vpp_ok = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R2 reset mode", rd_mode, 2'b00);
        chk("R2 reset ready", ready, 1);
        chk("R2 reset strobes", {prog_stb, erase_stb}, 0);
        wr(0, 8'h70);
        chk("R3 status mode", rd_mode, 2'b01);
        chk("R2 R11 reset status", rd_data, 8'h80);

        // identifier and array modes
        wr(0, 8'h90);
        chk("R3 ident mode", rd_mode, 2'b10);
        chk("R3 ident mfg", rd_data, 8'h89);
        addr = 20'h1; @(negedge clk);
        chk("R3 ident dev", rd_data, 8'hA2);
        wr(0, 8'hFF);
        chk("R3 array mode", rd_mode, 2'b00);
        chk("R3 array data", rd_data, 8'h00);
        repeat (3) @(negedge clk);
        chk("R3 mode holds", rd_mode, 2'b00);

        // write with chip-enable high is dropped
        wr_noce(0, 8'h70);
        chk("R1 ce_n high ignored", rd_mode, 2'b00);

        // byte writes
        wr(20'h12345, 8'h40);
        busy_cycles = 0;
        expect_op(0, 20'h12345, 8'h5A);
        wr(20'h12345, 8'h5A);
        wait_idle();
        chk("R4 busy length A", busy_cycles, PCY);
        wr(20'hFFFFF, 8'h40);
        busy_cycles = 0;
        expect_op(0, 20'hFFFFF, 8'h00);
        wr(20'hFFFFF, 8'h00);
        wait_idle();
        chk("R4 busy length B", busy_cycles, PCY);

        // erase, with read-array ignored while busy
        wr(20'h30000, 8'h20);
        busy_cycles = 0;
        expect_op(1, 20'h3ABCD, 8'hD0);
        wr(20'h3ABCD, 8'hD0);
        wr(0, 8'hFF);
        chk("R9 FF ignored busy", rd_mode, 2'b01);
        chk("R9 R11 busy status", rd_data, 8'h00);
        wait_idle();
        chk("R5 busy length", busy_cycles, ECY);
        chk("R11 status after erase", rd_data, 8'h80);

        // bad confirms
        s0 = strobes;
        wr(20'h30000, 8'h20);
        wr(20'h30000, 8'h5A);
        chk("R6 bad data status", rd_data, 8'hB0);
        chk("R6 ready stays", ready, 1);
        wr(0, 8'h50);
        chk("R8 clear status", rd_data, 8'h80);
        wr(20'h30000, 8'h20);
        wr(20'h40000, 8'hD0);
        chk("R6 bad block status", rd_data, 8'hB0);
        chk("R6 no strobe", strobes, s0);
        wr(0, 8'h50);

        // voltage low abort and lock
        vpp_ok = 0;
        wr(20'h00001, 8'h40);
        wr(20'h00001, 8'h33);
        chk("R7 vpp low status", rd_data, 8'h88);
        vpp_ok = 1;
        wr(20'h00002, 8'h40);
        wr(20'h00002, 8'h77);
        wr(20'h20000, 8'h20);
        wr(20'h20000, 8'hD0);
        chk("R8 locked status", rd_data, 8'h88);
        chk("R7 R8 no strobe", strobes, s0);
        chk("R8 locked ready", ready, 1);
        wr(0, 8'h50);
        chk("R8 cleared", rd_data, 8'h80);
        expect_op(0, 20'h00003, 8'hC3);
        wr(20'h00003, 8'h40);
        wr(20'h00003, 8'hC3);
        wait_idle();

        // suspend / resume
        wr(20'h50000, 8'h20);
        busy_cycles = 0;
        expect_op(1, 20'h5FFFF, 8'hD0);
        wr(20'h5FFFF, 8'hD0);
        repeat (5) @(negedge clk);
        wr(0, 8'hB0);
        chk("R10 suspended ready", ready, 1);
        chk("R10 suspended status", rd_data, 8'hC0);
        s0 = busy_cycles;
        wr(0, 8'hFF);
        chk("R10 array in suspend", rd_mode, 2'b00);
        repeat (10) @(negedge clk);
        chk("R10 count frozen", busy_cycles, s0);
        wr(0, 8'hD0);
        chk("R10 resumed mode", rd_mode, 2'b01);
        chk("R10 resumed busy", ready, 0);
        wait_idle();
        chk("R10 total busy", busy_cycles, ECY);

        chk("R4 R5 scoreboard drained", q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule